// File: doc/BRIEF.md
# External Bus Strobe Generator

This block converts an internal request for an off-chip access into the active-low control strobes of an external memory bus. A request names one of four target spaces and a transfer direction. From these the block produces a select line for each of the program, data and I/O spaces, a shared access strobe, separate read and write enables, a read/write direction line and a request line for the extended global data space. Each output group has an output-enable signal that the pad ring uses for tri-state control.

An access starts when `req_valid` is sampled high while the block is idle. The space and direction are captured at that point and stay fixed until `req_valid` is sampled low. The write enable lags the other strobes by `WE_DELAY` clocks, which gives the data bus a setup window. When the external interface is disabled, no strobe moves and a one-clock illegal-access pulse is raised instead. The `GLOBAL_EN` parameter selects whether the global space is built; when it is left out, global requests are treated as illegal. A visibility-mode indicator reports when the data bus is being driven outward.

Top module: `ext_strobe_gen`

## Requirements
- R1: While `rst_n` is low, every strobe output (`ps_n`, `ds_n`, `is_n`, `strb_n`, `rd_n`, `we_n`, `rw_n`, `br_n`, `vis_oe_n`) is high, `illegal_acc` is low, `sel_oe` and `br_oe` are low, and `strb_oe`, `rd_oe`, `we_oe` and `rw_oe` are high when neither power-down nor emulation-off is asserted.
- R2: If `req_valid` is sampled high at a rising edge while idle and `ext_en` is high, then after that edge `strb_n` and the select for the requested space go low. The space encoding is 0 program (`ps_n`), 1 data (`ds_n`), 2 I/O (`is_n`) and 3 global. At most one select is ever low.
- R3: An access to space 3 drives `ds_n` and `br_n` low together. `br_n` is high on any other access.
- R4: During a read (`req_write` = 0), `rd_n` is low whenever `strb_n` is low, and `we_n` and `rw_n` stay high.
- R5: During a write, `rw_n` is low whenever `strb_n` is low, `rd_n` stays high, and `we_n` falls `WE_DELAY` clocks (default 1) after `strb_n` falls. If the access is still in progress, `we_n` stays low until the access ends.
- R6: After the first rising edge that samples `req_valid` low during an access, all strobes are high again in the same cycle.
- R7: Changes on `req_space` and `req_write` while an access is in progress have no effect on the strobes.
- R8: If `ext_en` is low when an access starts, no strobe goes low. `illegal_acc` is high for exactly the one cycle after the starting edge, even if `req_valid` stays high. A new pulse needs `req_valid` to be sampled low first.
- R9: `sel_oe` and `br_oe` are low while reset, `pwr_down` or `emu_off` is active. `strb_oe` and `rw_oe` are low while `pwr_down` or `emu_off` is high. `rd_oe` and `we_oe` are low while `emu_off` is high.
- R10: `vis_oe_n` is low exactly when `vis_mode` is high and a write access has its strobes asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held for the length of the access |
| req_space | input | 2 | Target space: 0 program, 1 data, 2 I/O, 3 global |
| req_write | input | 1 | 1 = write, 0 = read |
| ext_en | input | 1 | External interface enable |
| pwr_down | input | 1 | Power-down state |
| emu_off | input | 1 | Emulation-off state |
| vis_mode | input | 1 | Visibility mode |
| ps_n | output | 1 | Program space select, active low |
| ds_n | output | 1 | Data space select, active low |
| is_n | output | 1 | I/O space select, active low |
| strb_n | output | 1 | Common access strobe, active low |
| rd_n | output | 1 | Read enable, active low |
| we_n | output | 1 | Write enable, active low |
| rw_n | output | 1 | Direction: high read, low write |
| br_n | output | 1 | Global space request, active low |
| sel_oe | output | 1 | Output enable for the three space selects |
| br_oe | output | 1 | Output enable for `br_n` |
| strb_oe | output | 1 | Output enable for `strb_n` |
| rd_oe | output | 1 | Output enable for `rd_n` |
| we_oe | output | 1 | Output enable for `we_n` |
| rw_oe | output | 1 | Output enable for `rw_n` |
| vis_oe_n | output | 1 | Data bus drive indicator in visibility mode, active low |
| illegal_acc | output | 1 | One-cycle pulse on a blocked access |

## Verification
The selects, `strb_n`, `rd_n`, `rw_n`, `br_n` and `vis_oe_n` change in the cycle after the rising edge that samples a request start. `we_n` follows `WE_DELAY` edges later. All strobes return high one edge after the release is sampled, and `illegal_acc` shows its pulse one edge after a blocked start. The output enables are combinational, so they follow `pwr_down`, `emu_off` and reset in the same cycle. The bench drives inputs on the falling clock edge and keeps a cycle-level reference model that advances on each rising edge. It compares every output at the next falling edge, so each result is sampled in the cycle it is due, after the edge that produces it.

// File: rtl/esg_pkg.sv
package esg_pkg;
   typedef enum logic [1:0] {
      SP_PROG = 2'd0,
      SP_DATA = 2'd1,
      SP_IO   = 2'd2,
      SP_GLOB = 2'd3
   } space_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_BLOCK  = 2'd3
   } phase_e;

   localparam int unsigned NUM_SEL = 3;
endpackage

// File: rtl/esg_ctrl.sv
module esg_ctrl
   import esg_pkg::*;
#(
   parameter int unsigned WE_DELAY  = 1,
   parameter bit          GLOBAL_EN = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  space_e req_space,
   input  logic   req_write,
   input  logic   ext_en,
   output phase_e phase,
   output space_e lat_space,
   output logic   lat_write,
   output logic   illegal
);
   localparam int unsigned CNT_W = (WE_DELAY < 2) ? 1 : $clog2(WE_DELAY);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WE_DELAY - 1);

   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q;
   logic             start;
   logic             legal;

   assign start = (phase_q == PH_IDLE) && req_valid;

   generate
      if (GLOBAL_EN) begin : g_glob
         assign legal = ext_en;
      end else begin : g_noglob
         assign legal = ext_en && (req_space != SP_GLOB);
      end
   endgenerate

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (req_valid) phase_d = legal ? PH_SETUP : PH_BLOCK;
         PH_SETUP:  if (!req_valid) phase_d = PH_IDLE;
                    else if (cnt_q == CNT_LAST) phase_d = PH_ACTIVE;
         PH_ACTIVE: if (!req_valid) phase_d = PH_IDLE;
         PH_BLOCK:  if (!req_valid) phase_d = PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         lat_space <= SP_PROG;
         lat_write <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         illegal <= start && !legal;
         if (phase_q == PH_SETUP) cnt_q <= cnt_q + 1'b1;
         else                     cnt_q <= '0;
         if (start) begin
            lat_space <= req_space;
            lat_write <= req_write;
         end
      end
   end

   assign phase = phase_q;
endmodule

// File: rtl/esg_decode.sv
module esg_decode
   import esg_pkg::*;
(
   input  phase_e phase,
   input  space_e lat_space,
   input  logic   lat_write,
   input  logic   vis_mode,
   output logic [NUM_SEL-1:0] sel_n,
   output logic   strb_n,
   output logic   rd_n,
   output logic   we_n,
   output logic   rw_n,
   output logic   br_n,
   output logic   vis_oe_n
);
   logic on;

   assign on = (phase == PH_SETUP) || (phase == PH_ACTIVE);

   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
         if (i == int'(SP_DATA)) begin : g_data
            assign sel_n[i] = !(on && ((lat_space == SP_DATA) ||
                                       (lat_space == SP_GLOB)));
         end else begin : g_plain
            assign sel_n[i] = !(on && (lat_space == space_e'(i)));
         end
      end
   endgenerate

   assign strb_n   = !on;
   assign rd_n     = !(on && !lat_write);
   assign rw_n     = !(on && lat_write);
   assign we_n     = !((phase == PH_ACTIVE) && lat_write);
   assign br_n     = !(on && (lat_space == SP_GLOB));
   assign vis_oe_n = !(vis_mode && on && lat_write);
endmodule

// File: rtl/esg_oe.sv
module esg_oe (
   input  logic rst_n,
   input  logic pwr_down,
   input  logic emu_off,
   output logic sel_oe,
   output logic br_oe,
   output logic strb_oe,
   output logic rd_oe,
   output logic we_oe,
   output logic rw_oe
);
   logic live;

   assign live    = !pwr_down && !emu_off;
   assign sel_oe  = live && rst_n;
   assign br_oe   = live && rst_n;
   assign strb_oe = live;
   assign rw_oe   = live;
   assign rd_oe   = !emu_off;
   assign we_oe   = !emu_off;
endmodule

// File: rtl/ext_strobe_gen.sv
module ext_strobe_gen
   import esg_pkg::*;
#(
   parameter int unsigned WE_DELAY  = 1,
   parameter bit          GLOBAL_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_space,
   input  logic       req_write,
   input  logic       ext_en,
   input  logic       pwr_down,
   input  logic       emu_off,
   input  logic       vis_mode,
   output logic       ps_n,
   output logic       ds_n,
   output logic       is_n,
   output logic       strb_n,
   output logic       rd_n,
   output logic       we_n,
   output logic       rw_n,
   output logic       br_n,
   output logic       sel_oe,
   output logic       br_oe,
   output logic       strb_oe,
   output logic       rd_oe,
   output logic       we_oe,
   output logic       rw_oe,
   output logic       vis_oe_n,
   output logic       illegal_acc
);
   generate
      if (WE_DELAY < 1) begin : g_bad_delay
         $error("ext_strobe_gen: WE_DELAY must be at least 1");
      end
   endgenerate

   phase_e             phase;
   space_e             lat_space;
   logic               lat_write;
   logic [NUM_SEL-1:0] sel_n;

   esg_ctrl #(.WE_DELAY(WE_DELAY), .GLOBAL_EN(GLOBAL_EN)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_space (space_e'(req_space)),
      .req_write (req_write),
      .ext_en    (ext_en),
      .phase     (phase),
      .lat_space (lat_space),
      .lat_write (lat_write),
      .illegal   (illegal_acc)
   );

   esg_decode dec_i (
      .phase     (phase),
      .lat_space (lat_space),
      .lat_write (lat_write),
      .vis_mode  (vis_mode),
      .sel_n     (sel_n),
      .strb_n    (strb_n),
      .rd_n      (rd_n),
      .we_n      (we_n),
      .rw_n      (rw_n),
      .br_n      (br_n),
      .vis_oe_n  (vis_oe_n)
   );

   esg_oe oe_i (
      .rst_n    (rst_n),
      .pwr_down (pwr_down),
      .emu_off  (emu_off),
      .sel_oe   (sel_oe),
      .br_oe    (br_oe),
      .strb_oe  (strb_oe),
      .rd_oe    (rd_oe),
      .we_oe    (we_oe),
      .rw_oe    (rw_oe)
   );

   assign ps_n = sel_n[SP_PROG];
   assign ds_n = sel_n[SP_DATA];
   assign is_n = sel_n[SP_IO];
endmodule

// File: rtl/esg_checker.sv
module esg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_space,
   input logic       req_write,
   input logic       ext_en,
   input logic       pwr_down,
   input logic       emu_off,
   input logic       vis_mode,
   input logic       ps_n,
   input logic       ds_n,
   input logic       is_n,
   input logic       strb_n,
   input logic       rd_n,
   input logic       we_n,
   input logic       rw_n,
   input logic       br_n,
   input logic       sel_oe,
   input logic       br_oe,
   input logic       strb_oe,
   input logic       rd_oe,
   input logic       we_oe,
   input logic       rw_oe,
   input logic       vis_oe_n,
   input logic       illegal_acc
);
   p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~ps_n, ~ds_n, ~is_n}));

   p_strb_with_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !strb_n |-> !(ps_n && ds_n && is_n));

   p_br_with_ds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !br_n |-> (!ds_n && !strb_n));

   p_read_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (we_n && rw_n && !strb_n));

   p_we_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!rw_n && !strb_n && rd_n));

   p_we_lags_strb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> $past(!strb_n));

   p_release_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_n) |-> (ps_n && ds_n && is_n && rd_n && we_n && rw_n && br_n));

   p_ill_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_acc |=> !illegal_acc);

   p_ill_no_strb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_acc |-> strb_n);

   p_emu_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      emu_off |-> !(sel_oe || br_oe || strb_oe || rd_oe || we_oe || rw_oe));

   p_pd_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !(sel_oe || br_oe || strb_oe || rw_oe));

   p_vis_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !vis_oe_n |-> (vis_mode && !rw_n && !strb_n));
endmodule

bind ext_strobe_gen esg_checker chk_i (.*);

// File: tb/ext_strobe_gen_tb.sv
`timescale 1ns/1ps
module ext_strobe_gen_tb_top;
   localparam int WE_DELAY = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_space = 2'd0;
   logic       req_write = 1'b0;
   logic       ext_en = 1'b1;
   logic       pwr_down = 1'b0;
   logic       emu_off = 1'b0;
   logic       vis_mode = 1'b0;
   logic ps_n, ds_n, is_n, strb_n, rd_n, we_n, rw_n, br_n;
   logic sel_oe, br_oe, strb_oe, rd_oe, we_oe, rw_oe, vis_oe_n, illegal_acc;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   ext_strobe_gen #(.WE_DELAY(WE_DELAY)) dut_i (.*);

   // reference model: 0 idle, 1 setup, 2 active, 3 blocked
   int         m_ph;
   int         m_cnt;
   logic [1:0] m_sp;
   logic       m_wr;
   logic       m_ill;
   logic       m_prev_on;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 0; m_cnt <= 0; m_sp <= 2'd0; m_wr <= 1'b0; m_ill <= 1'b0;
      end else begin
         m_ill <= 1'b0;
         case (m_ph)
            0: if (req_valid) begin
                  m_sp <= req_space; m_wr <= req_write; m_cnt <= 0;
                  if (ext_en) m_ph <= 1;
                  else begin m_ph <= 3; m_ill <= 1'b1; end
               end
            1: begin
                  m_cnt <= m_cnt + 1;
                  if (!req_valid) m_ph <= 0;
                  else if (m_cnt == WE_DELAY - 1) m_ph <= 2;
               end
            default: if (!req_valid) m_ph <= 0;
         endcase
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      bit on = (m_ph == 1) || (m_ph == 2);
      string stag;
      stag = ((m_ph == 2) && (req_space != m_sp || req_write != m_wr)) ? "R7" : "R2";
      chk({stag, " ps_n"}, ps_n, !(on && m_sp == 2'd0));
      chk({stag, " ds_n"}, ds_n, !(on && (m_sp == 2'd1 || m_sp == 2'd3)));
      chk({stag, " is_n"}, is_n, !(on && m_sp == 2'd2));
      chk("R2 strb_n", strb_n, !on);
      chk("R3 br_n", br_n, !(on && m_sp == 2'd3));
      chk("R4 rd_n", rd_n, !(on && !m_wr));
      chk("R5 rw_n", rw_n, !(on && m_wr));
      chk("R5 we_n", we_n, !(m_ph == 2 && m_wr));
      chk("R8 illegal_acc", illegal_acc, m_ill);
      chk("R9 sel_oe", sel_oe, !pwr_down && !emu_off);
      chk("R9 br_oe", br_oe, !pwr_down && !emu_off);
      chk("R9 strb_oe", strb_oe, !pwr_down && !emu_off);
      chk("R9 rw_oe", rw_oe, !pwr_down && !emu_off);
      chk("R9 rd_oe", rd_oe, !emu_off);
      chk("R9 we_oe", we_oe, !emu_off);
      chk("R10 vis_oe_n", vis_oe_n, !(vis_mode && on && m_wr));
      if (m_prev_on && !on)
         chk("R6 all high", {ps_n, ds_n, is_n, strb_n, rd_n, we_n, rw_n, br_n}, 8'hFF);
      m_prev_on = on;
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_all();
      end
   endtask

   task automatic access(logic [1:0] sp, logic wr, logic en, int hold);
      req_space = sp; req_write = wr; ext_en = en; req_valid = 1'b1;
      step(hold);
      req_valid = 1'b0;
      step(2);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      m_prev_on = 1'b0;
      // R1 reset state
      repeat (2) @(negedge clk);
      chk("R1 strobes", {ps_n, ds_n, is_n, strb_n, rd_n, we_n, rw_n, br_n, vis_oe_n}, 9'h1FF);
      chk("R1 illegal_acc", illegal_acc, 0);
      chk("R1 sel_oe", sel_oe, 0);
      chk("R1 br_oe", br_oe, 0);
      chk("R1 other oe", {strb_oe, rd_oe, we_oe, rw_oe}, 4'hF);
      rst_n = 1'b1;
      step(2);
      // directed cases
      access(2'd0, 1'b0, 1'b1, 4);   // R4 program read
      access(2'd2, 1'b1, 1'b1, 4);   // R5 I/O write
      access(2'd3, 1'b1, 1'b1, 3);   // R3 global write
      access(2'd1, 1'b0, 1'b1, 1);   // shortest access
      access(2'd1, 1'b1, 1'b1, 1);   // write released before we_n
      access(2'd2, 1'b0, 1'b0, 4);   // R8 blocked, held
      vis_mode = 1'b1;
      access(2'd1, 1'b1, 1'b1, 3);   // R10
      // R7: change attributes mid-access
      req_space = 2'd0; req_write = 1'b1; ext_en = 1'b1; req_valid = 1'b1;
      step(2);
      req_space = 2'd2; req_write = 1'b0;
      step(3);
      req_valid = 1'b0;
      step(2);
      // R9 enables
      pwr_down = 1'b1; step(1); pwr_down = 1'b0;
      emu_off = 1'b1;  step(1); emu_off = 1'b0;
      // random
      for (int c = 0; c < 4000; c++) begin
         if ($urandom % 4 == 0) req_valid = ~req_valid;
         req_space = 2'($urandom);
         req_write = 1'($urandom);
         ext_en    = ($urandom % 8) != 0;
         pwr_down  = ($urandom % 16) == 0;
         emu_off   = ($urandom % 16) == 0;
         vis_mode  = 1'($urandom);
         step(1);
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule